// File: doc/BRIEF.md
# Startup Fault Supervisor with Soft-Start

This block decides when a switching regulator's modulator may run. Every clock it takes digitized samples of four monitored quantities: the chip supply, the internal reference, the input line and a shutdown input. It compares each sample against its own thresholds and holds the modulator off until all four read good. Supply, reference and line each use a separate turn-on level and a lower turn-off level. The supply turn-on level is chosen at run time between a high start level and a low start level.

When all conditions are good, the block enables the modulator and starts a soft-start value at zero. The value climbs by a fixed step every few clocks until it reaches full scale. While the modulator is enabled, the block passes the smaller of the incoming error value and the soft-start value, so the duty cycle grows from zero. Any bad condition while the modulator is enabled drops the enable and raises a fault flag. The soft-start value then falls by a larger step each clock. A new start is allowed only after that value has dropped below a restart level.

Codes are 12-bit with 10 mV per LSB at the defaults. Supply turns on at 1500 (high start) or 900 (low start) and turns off below 850. Reference turns on at 475 and off below 450. Line turns on at 500 and off below 450. Shutdown trips above 50. The restart level is 50. Soft-start full scale is 500, rising by 25 every 4 clocks and falling by 30 per clock.

Top module: `sfs_supervisor`

## Requirements
- R1: After reset, enable, fault flag, soft-start value and limited error value are all 0.
- R2: Supply becomes good when its code is at least 1500 with `hi_start_sel_i`=1, or at least 900 with `hi_start_sel_i`=0. Once good, it stays good until the code drops below 850, whatever the select does.
- R3: Line becomes good at a code of 500 or more and turns bad only below 450.
- R4: Reference becomes good at a code of 475 or more and turns bad only below 450.
- R5: Shutdown counts as a fault when its code is above 50. A code of exactly 50 has no effect.
- R6: Each sample is registered on the clock edge after it is applied. The enable rises two clocks after the last condition becomes good, and falls two clocks after any condition goes bad.
- R7: The soft-start value is 0 on the first enabled clock. It rises by 25 on every fourth clock after that and saturates at 500.
- R8: When a fault ends an enabled phase, the fault flag is 1 while the soft-start value discharges. From the clock after the enable falls, the value decreases by 30 per clock.
- R9: The fault flag clears, and a start becomes possible, only on the clock after the soft-start value has read below 50. A value of exactly 50 keeps the block waiting.
- R10: The limited error output equals min(error input, soft-start value) while enabled and 0 otherwise.
- R11: The soft-start value never exceeds 500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_code_i | input | 12 | Supply sample code |
| ref_code_i | input | 12 | Reference sample code |
| line_code_i | input | 12 | Line sample code |
| sd_code_i | input | 12 | Shutdown input sample code |
| hi_start_sel_i | input | 1 | 1 selects the high supply turn-on level |
| err_code_i | input | 12 | Error value from the loop |
| en_o | output | 1 | Modulator enable |
| fault_o | output | 1 | Fault discharge in progress |
| ss_o | output | 12 | Soft-start clamp value |
| err_lim_o | output | 12 | Error value limited by soft-start |

## Verification
Two of the block's functions can act in the same clock. The first is the edge where a fault ends an enabled phase while the soft-start step still applies. The bench provokes this by removing the line input after the soft-start value has saturated. It then checks that the value stays at 500 on the clock the enable drops and falls by 30 only on the next clock. The second pair is the restart decision and the last discharge step. The bench checks that the flag is still set when the value reads exactly 50, and that the flag clears on the same clock the value reaches 0.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_WAIT_DIS = 2'd1,
        ST_SOFT     = 2'd2,
        ST_RUN      = 2'd3
    } sup_state_e;

    typedef enum logic {
        RAMP_FALL = 1'b0,
        RAMP_RISE = 1'b1
    } ramp_mode_e;

    localparam int unsigned NUM_MON  = 4;
    localparam int unsigned MON_VDD  = 0;
    localparam int unsigned MON_REF  = 1;
    localparam int unsigned MON_LINE = 2;
    localparam int unsigned MON_SD   = 3;

endpackage

// File: rtl/sfs_hyst_cmp.sv
module sfs_hyst_cmp #(
    parameter int unsigned W        = 12,
    parameter bit          LOW_GOOD = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] on_thr_i,
    input  logic [W-1:0] off_thr_i,
    output logic         good_o
);

    typedef struct packed {
        logic good;
    } cmp_state_t;

    cmp_state_t s_d, s_q;

    generate
        if (LOW_GOOD) begin : g_low
            // input is healthy while it stays at or under its limit
            always_comb begin
                s_d      = s_q;
                s_d.good = (code_i <= on_thr_i) && (code_i <= off_thr_i);
            end

            // R5: a code above the limit reads bad on the next edge
            a_r5_trip_above: assert property (@(posedge clk) disable iff (!rst_n)
                (code_i > off_thr_i) |=> !good_o);
        end else begin : g_hyst
            // rising level to turn good, lower level to turn bad
            always_comb begin
                s_d = s_q;
                if (s_q.good) s_d.good = (code_i >= off_thr_i);
                else          s_d.good = (code_i >= on_thr_i);
            end

            // R2, R3, R4: hysteresis holds the present verdict inside the band
            a_r3_keep_good: assert property (@(posedge clk) disable iff (!rst_n)
                (good_o && code_i >= off_thr_i) |=> good_o);
            a_r3_keep_bad: assert property (@(posedge clk) disable iff (!rst_n)
                (!good_o && code_i < on_thr_i) |=> !good_o);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign good_o = s_q.good;

endmodule

// File: rtl/sfs_ss_ramp.sv
module sfs_ss_ramp
    import sfs_pkg::*;
#(
    parameter int unsigned W    = 12,
    parameter int unsigned MAX  = 500,
    parameter int unsigned UP   = 25,
    parameter int unsigned DN   = 30,
    parameter int unsigned TICK = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ramp_mode_e   mode_i,
    output logic [W-1:0] ss_o
);

    localparam int unsigned TW = (TICK > 1) ? $clog2(TICK) : 1;

    typedef struct packed {
        logic [W-1:0]  ss;
        logic [TW-1:0] tick;
    } ramp_state_t;

    ramp_state_t s_d, s_q;
    logic [W:0]  sum_up;

    always_comb begin
        s_d    = s_q;
        sum_up = {1'b0, s_q.ss} + (W+1)'(UP);
        if (mode_i == RAMP_RISE) begin
            if (s_q.tick == TW'(TICK - 1)) begin
                s_d.tick = '0;
                s_d.ss   = (sum_up >= (W+1)'(MAX)) ? W'(MAX) : sum_up[W-1:0];
            end else begin
                s_d.tick = s_q.tick + 1'b1;
            end
        end else begin
            s_d.tick = '0;
            s_d.ss   = (s_q.ss >= W'(DN)) ? (s_q.ss - W'(DN)) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ss_o = s_q.ss;

    // R11: full scale is a hard ceiling
    a_r11_ss_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ss_o <= W'(MAX));
    // R8: discharge removes a whole step each clock while there is room
    a_r8_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == RAMP_FALL && ss_o >= W'(DN)) |=> (ss_o == $past(ss_o) - W'(DN)));

endmodule

// File: rtl/sfs_supervisor.sv
module sfs_supervisor
    import sfs_pkg::*;
#(
    parameter int unsigned W          = 12,
    parameter int unsigned VDD_ON_HI  = 1500,
    parameter int unsigned VDD_ON_LO  = 900,
    parameter int unsigned VDD_OFF    = 850,
    parameter int unsigned REF_ON     = 475,
    parameter int unsigned REF_OFF    = 450,
    parameter int unsigned LINE_ON    = 500,
    parameter int unsigned LINE_OFF   = 450,
    parameter int unsigned SD_TRIP    = 50,
    parameter int unsigned SS_RESTART = 50,
    parameter int unsigned SS_MAX     = 500,
    parameter int unsigned SS_UP      = 25,
    parameter int unsigned SS_DN      = 30,
    parameter int unsigned SS_TICK    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] vdd_code_i,
    input  logic [W-1:0] ref_code_i,
    input  logic [W-1:0] line_code_i,
    input  logic [W-1:0] sd_code_i,
    input  logic         hi_start_sel_i,
    input  logic [W-1:0] err_code_i,
    output logic         en_o,
    output logic         fault_o,
    output logic [W-1:0] ss_o,
    output logic [W-1:0] err_lim_o
);

    logic [NUM_MON-1:0][W-1:0] mon_code;
    logic [NUM_MON-1:0][W-1:0] mon_on;
    logic [NUM_MON-1:0][W-1:0] mon_off;
    logic [NUM_MON-1:0]        mon_good;
    logic                      all_good;

    always_comb begin
        mon_code[MON_VDD]  = vdd_code_i;
        mon_on[MON_VDD]    = hi_start_sel_i ? W'(VDD_ON_HI) : W'(VDD_ON_LO);
        mon_off[MON_VDD]   = W'(VDD_OFF);
        mon_code[MON_REF]  = ref_code_i;
        mon_on[MON_REF]    = W'(REF_ON);
        mon_off[MON_REF]   = W'(REF_OFF);
        mon_code[MON_LINE] = line_code_i;
        mon_on[MON_LINE]   = W'(LINE_ON);
        mon_off[MON_LINE]  = W'(LINE_OFF);
        mon_code[MON_SD]   = sd_code_i;
        mon_on[MON_SD]     = W'(SD_TRIP);
        mon_off[MON_SD]    = W'(SD_TRIP);
    end

    generate
        for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
            sfs_hyst_cmp #(
                .W       (W),
                .LOW_GOOD(g == MON_SD)
            ) u_cmp (
                .clk      (clk),
                .rst_n    (rst_n),
                .code_i   (mon_code[g]),
                .on_thr_i (mon_on[g]),
                .off_thr_i(mon_off[g]),
                .good_o   (mon_good[g])
            );
        end
    endgenerate

    assign all_good = &mon_good;

    typedef struct packed {
        sup_state_e state;
    } sup_reg_t;

    sup_reg_t   s_d, s_q;
    ramp_mode_e ramp_mode;
    logic [W-1:0] ss_val;

    // sequencer: off -> soft -> run, any fault -> discharge -> off
    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_OFF: begin
                if (all_good && ss_val == '0) s_d.state = ST_SOFT;
            end
            ST_WAIT_DIS: begin
                if (ss_val < W'(SS_RESTART)) s_d.state = ST_OFF;
            end
            ST_SOFT: begin
                if (!all_good)                 s_d.state = ST_WAIT_DIS;
                else if (ss_val == W'(SS_MAX)) s_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (!all_good) s_d.state = ST_WAIT_DIS;
            end
            default: s_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_OFF};
        else        s_q <= s_d;
    end

    assign ramp_mode = (s_q.state == ST_SOFT || s_q.state == ST_RUN) ? RAMP_RISE : RAMP_FALL;

    sfs_ss_ramp #(
        .W   (W),
        .MAX (SS_MAX),
        .UP  (SS_UP),
        .DN  (SS_DN),
        .TICK(SS_TICK)
    ) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .mode_i(ramp_mode),
        .ss_o  (ss_val)
    );

    assign en_o      = (s_q.state == ST_SOFT) || (s_q.state == ST_RUN);
    assign fault_o   = (s_q.state == ST_WAIT_DIS);
    assign ss_o      = ss_val;
    assign err_lim_o = !en_o ? '0 : ((err_code_i < ss_val) ? err_code_i : ss_val);

    // R6: enabling needs every monitor good on the prior edge
    a_r6_en_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> $past(all_good));
    // R6, R8: a bad monitor ends the enabled phase on the next edge
    a_r8_fault_stops_en: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !all_good) |=> (!en_o && fault_o));
    // R7: every start begins from an empty soft-start value
    a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_o) |-> (ss_val == '0));
    // R9: no release while the value is at or over the restart level
    a_r9_wait_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && ss_val >= W'(SS_RESTART)) |=> fault_o);
    // R10: the limited error never passes the soft-start value
    a_r10_err_limited: assert property (@(posedge clk) disable iff (!rst_n)
        err_lim_o <= ss_val);

endmodule

// File: tb/test_sfs_supervisor.sv
module test_sfs_supervisor;

    localparam int W = 12;
    localparam int SIG_EN = 0, SIG_FAULT = 1, SIG_SS = 2, SIG_ERR = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] vdd_code = '0, ref_code = '0, line_code = '0, sd_code = '0, err_code = '0;
    logic         hi_sel = 1'b0;
    logic         en, fault;
    logic [W-1:0] ss, err_lim;

    int cyc_cnt = 0;
    int n_run   = 0;
    int n_fail  = 0;

    typedef struct {
        int    due;
        int    sig;
        int    exp;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    sfs_supervisor i_sfs_supervisor (
        .clk           (clk),
        .rst_n         (rst_n),
        .vdd_code_i    (vdd_code),
        .ref_code_i    (ref_code),
        .line_code_i   (line_code),
        .sd_code_i     (sd_code),
        .hi_start_sel_i(hi_sel),
        .err_code_i    (err_code),
        .en_o          (en),
        .fault_o       (fault),
        .ss_o          (ss),
        .err_lim_o     (err_lim)
    );

    function automatic int pick(int sig);
        case (sig)
            SIG_EN:    return int'(en);
            SIG_FAULT: return int'(fault);
            SIG_SS:    return int'(ss);
            default:   return int'(err_lim);
        endcase
    endfunction

    // driver side: queue an expected value for d cycles from now
    task automatic expect_at(int d, int sig, int val, string req);
        exp_t e;
        e.due = cyc_cnt + d;
        e.sig = sig;
        e.exp = val;
        e.req = req;
        sb.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_sig(int sig, int val, int lim, string req);
        int k = 0;
        while (pick(sig) != val && k < lim) begin
            step(1);
            k++;
        end
        if (k >= lim) begin
            n_run++;
            n_fail++;
            $display("FAIL %s: signal %0d actual %0d expected %0d (timeout)", req, sig, pick(sig), val);
        end
    endtask

    // monitor side: compare due items away from the active edge
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc_cnt) begin
                n_run++;
                if (pick(sb[i].sig) != sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s: signal %0d actual %0d expected %0d",
                             sb[i].req, sb[i].sig, pick(sb[i].sig), sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        expect_at(0, SIG_EN, 0, "R1");
        expect_at(0, SIG_FAULT, 0, "R1");
        expect_at(0, SIG_SS, 0, "R1");
        expect_at(0, SIG_ERR, 0, "R1");
        step(1);

        // R2: high start level not reached at 1000
        hi_sel = 1'b1; vdd_code = 1000; ref_code = 500; line_code = 600; sd_code = 0; err_code = 4095;
        expect_at(5, SIG_EN, 0, "R2");
        step(6);

        // low start level: enable after two edges, ramp from zero
        hi_sel = 1'b0;
        expect_at(1, SIG_EN, 0, "R6");
        expect_at(2, SIG_EN, 1, "R6");
        expect_at(2, SIG_SS, 0, "R7");
        expect_at(2, SIG_ERR, 0, "R10");
        expect_at(5, SIG_SS, 0, "R7");
        expect_at(6, SIG_SS, 25, "R7");
        expect_at(6, SIG_ERR, 25, "R10");
        expect_at(81, SIG_SS, 475, "R7");
        expect_at(82, SIG_SS, 500, "R7");
        expect_at(90, SIG_SS, 500, "R11");
        step(91);

        err_code = 300;
        expect_at(0, SIG_ERR, 300, "R10");
        step(1);
        hi_sel = 1'b1;  // R2: select change does not drop a good supply
        expect_at(3, SIG_EN, 1, "R2");
        step(4);
        line_code = 470;  // R3: inside band, stays good
        expect_at(3, SIG_EN, 1, "R3");
        step(4);

        // line fault coinciding with saturated ramp; discharge to restart level
        line_code = 440;
        expect_at(1, SIG_EN, 1, "R6");
        expect_at(2, SIG_EN, 0, "R3");
        expect_at(2, SIG_FAULT, 1, "R8");
        expect_at(2, SIG_ERR, 0, "R10");
        expect_at(2, SIG_SS, 500, "R8");
        expect_at(3, SIG_SS, 470, "R8");
        expect_at(17, SIG_SS, 50, "R9");
        expect_at(17, SIG_FAULT, 1, "R9");
        expect_at(18, SIG_SS, 20, "R9");
        expect_at(18, SIG_FAULT, 1, "R9");
        expect_at(19, SIG_FAULT, 0, "R9");
        expect_at(19, SIG_SS, 0, "R9");
        step(25);

        line_code = 470;  // R3: below turn-on level, no restart
        expect_at(5, SIG_EN, 0, "R3");
        step(6);
        line_code = 500;
        expect_at(2, SIG_EN, 1, "R3");
        expect_at(2, SIG_SS, 0, "R7");
        step(10);
        expect_at(0, SIG_ERR, 50, "R10");

        sd_code = 50;  // R5 boundary: no effect
        expect_at(3, SIG_EN, 1, "R5");
        step(4);
        sd_code = 51;
        expect_at(2, SIG_EN, 0, "R5");
        expect_at(2, SIG_FAULT, 1, "R5");
        step(3);
        sd_code = 0;
        wait_sig(SIG_EN, 1, 400, "R9");
        expect_at(0, SIG_SS, 0, "R7");
        expect_at(0, SIG_FAULT, 0, "R8");
        step(3);

        ref_code = 440;
        expect_at(2, SIG_EN, 0, "R4");
        step(3);
        ref_code = 460;
        wait_sig(SIG_FAULT, 0, 400, "R4");
        expect_at(5, SIG_EN, 0, "R4");
        step(6);
        ref_code = 475;
        expect_at(2, SIG_EN, 1, "R4");
        step(3);

        vdd_code = 849;
        expect_at(2, SIG_EN, 0, "R2");
        expect_at(2, SIG_FAULT, 1, "R2");
        step(3);
        hi_sel = 1'b1;
        vdd_code = 1499;
        wait_sig(SIG_FAULT, 0, 400, "R2");
        expect_at(5, SIG_EN, 0, "R2");
        step(6);
        vdd_code = 1500;
        expect_at(2, SIG_EN, 1, "R2");
        step(4);

        if (sb.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule